// File: doc/BRIEF.md
# Outbound Address Translation Region Table

This block holds a small set of outbound translation regions. Each region maps a window of 64-bit CPU address space onto a window of 64-bit bus address space, and it carries a header descriptor for traffic through that window. Software fills the table one 32-bit word at a time through a simple write port. Each region has six words: low and high CPU base, low and high PCI base, and two descriptor words.

For every outgoing CPU address, the block looks for the lowest-numbered enabled region whose window contains the address. One clock later it returns the translated bus address and the header fields for that region: transaction type, function number, device number, bus number and a flag that tells whether the requester ID comes from the descriptor. When the descriptor does not force the requester ID, the device and bus numbers are taken from the captured values presented with the request. An address that hits no region comes back unchanged, with a miss flag.

Top module: `otr_table`

## Requirements
- R1: While reset is high, and on the first cycle after it, rspValid, rspMiss, rspHardId and rspAddr are 0, and every region is disabled, so the first lookup after reset misses.
- R2: A write selects a word with wrWord: 0 CPU base low, 1 CPU base high, 2 PCI base low, 3 PCI base high, 4 descriptor word 0, 5 descriptor word 1. The new value is used from the cycle after the write. A lookup in the same cycle as the write still sees the old contents.
- R3: A write with wrRegion at or above the region count, or with wrWord at 6 or 7, changes no region. A region is enabled only while at least one of its six words is nonzero, so writing all six words to zero disables it.
- R4: The window size bit count is bits 5:0 of the CPU base low word, and any value below 8 acts as 8. Bits 7:0 of both stored base addresses are taken as zero. An address hits when its bits at and above the bit count equal those of the CPU base.
- R5: On a hit, rspAddr takes the PCI base bits at and above the bit count and the request address bits below it.
- R6: If several regions hit, the lowest-numbered one is used, and rspRegion reports its index.
- R7: On a miss, rspMiss is 1, rspAddr equals the request address, and rspRegion, rspType, rspFunc, rspDev, rspBus and rspHardId are 0.
- R8: rspType carries bits 3:0 of descriptor word 0. Code 0x2 means memory, 0x6 means I/O and 0xA means normal message.
- R9: In a region whose type is 0xA, the bit count is 17 whatever the CPU base low word holds, and the PCI base is taken as zero.
- R10: rspFunc is always bits 26:24 of descriptor word 0, and rspHardId is bit 23. With bit 23 set, rspDev is bits 31:27 of descriptor word 0 and rspBus is bits 7:0 of descriptor word 1. With bit 23 clear, rspDev and rspBus are capDev and capBus as sampled with the request.
- R11: rspValid follows reqValid by exactly one cycle. In a cycle without a request, all result outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write strobe |
| wrRegion | input | $clog2(NUM_REGIONS)+1 | Region index of the write |
| wrWord | input | 3 | Word select within the region |
| wrData | input | 32 | Write data |
| reqValid | input | 1 | Lookup request |
| reqAddr | input | 64 | CPU address to translate |
| capBus | input | 8 | Captured bus number |
| capDev | input | 5 | Captured device number |
| rspValid | output | 1 | Result valid, one cycle after reqValid |
| rspMiss | output | 1 | No enabled region matched |
| rspRegion | output | $clog2(NUM_REGIONS) | Index of the region used |
| rspAddr | output | 64 | Translated address, or the request address on a miss |
| rspType | output | 4 | Transaction type code |
| rspHardId | output | 1 | Requester ID forced from the descriptor |
| rspFunc | output | 3 | Function number |
| rspDev | output | 5 | Device number |
| rspBus | output | 8 | Bus number |

## Verification
The assertions assume that reqValid, reqAddr, capBus and capDev are stable and known at every rising edge after reset. They also assume that reset is held for at least one edge before the first request. The bench changes every input only on falling edges and drives a defined value on every input from time zero. It keeps capBus and capDev constant over each request cycle, so the one-cycle-later comparisons in the checker refer to the values the design actually sampled.

// File: rtl/otr_pkg.sv
package otr_pkg;

  localparam int ADDR_W     = 64;
  localparam int WORD_W     = 32;
  localparam int NUM_WORDS  = 6;
  localparam int WORD_SEL_W = 3;
  localparam int SIZE_W     = 6;

  // word select codes inside one region
  localparam logic [WORD_SEL_W-1:0] W_CPU_LO = 3'd0;
  localparam logic [WORD_SEL_W-1:0] W_CPU_HI = 3'd1;
  localparam logic [WORD_SEL_W-1:0] W_PCI_LO = 3'd2;
  localparam logic [WORD_SEL_W-1:0] W_PCI_HI = 3'd3;
  localparam logic [WORD_SEL_W-1:0] W_DESC0  = 3'd4;
  localparam logic [WORD_SEL_W-1:0] W_DESC1  = 3'd5;

  // transaction type codes in descriptor word 0 bits 3:0
  localparam logic [3:0] TYPE_MEM = 4'h2;
  localparam logic [3:0] TYPE_IO  = 4'h6;
  localparam logic [3:0] TYPE_MSG = 4'hA;

  localparam logic [SIZE_W-1:0] MIN_SIZE = 6'd8;
  localparam logic [SIZE_W-1:0] MSG_SIZE = 6'd17;

  // strobes from control to datapath
  typedef struct packed {
    logic                 wrHit;
    logic [NUM_WORDS-1:0] wordHot;
    logic [WORD_W-1:0]    wrData;
    logic                 lookup;
  } ctrlStrobe_t;

  // header fields of one region
  typedef struct packed {
    logic [3:0] txnType;
    logic       hardId;
    logic [2:0] func;
    logic [4:0] dev;
    logic [7:0] bus;
  } descFields_t;

endpackage

// File: rtl/otr_ctrl.sv
module otr_ctrl
  import otr_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  parameter int REGION_W    = $clog2(NUM_REGIONS) + 1
) (
  input  logic                  wrEn,
  input  logic [REGION_W-1:0]   wrRegion,
  input  logic [WORD_SEL_W-1:0] wrWord,
  input  logic [WORD_W-1:0]     wrData,
  input  logic                  reqValid,
  output ctrlStrobe_t           strobe,
  output logic [NUM_REGIONS-1:0] regionHot
);

  logic regionOk;
  logic wordOk;
  logic [NUM_WORDS-1:0] wordDec;

  assign regionOk = (wrRegion < REGION_W'(NUM_REGIONS));
  assign wordOk   = (wrWord < WORD_SEL_W'(NUM_WORDS));

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    assign wordDec[w] = (wrWord == WORD_SEL_W'(w));
  end

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
    assign regionHot[r] = regionOk && (wrRegion == REGION_W'(r));
  end

  always_comb begin
    strobe.wrHit   = wrEn && regionOk && wordOk;
    strobe.wordHot = wordDec;
    strobe.wrData  = wrData;
    strobe.lookup  = reqValid;
  end

endmodule

// File: rtl/otr_region.sv
module otr_region
  import otr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [NUM_WORDS-1:0] wordHot,
  input  logic [WORD_W-1:0]    wrData,
  input  logic [ADDR_W-1:0]    reqAddr,
  output logic                 hit,
  output logic [ADDR_W-1:0]    xlatAddr,
  output descFields_t          desc
);

  logic [WORD_W-1:0] regWord [NUM_WORDS];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_WORDS; i++) begin
      if (rst) begin
        regWord[i] <= '0;
      end else if (we && wordHot[i]) begin
        regWord[i] <= wrData;
      end
    end
  end

  logic              enabled;
  logic              isMsg;
  logic [SIZE_W-1:0] rawSize;
  logic [SIZE_W-1:0] sizeBits;
  logic [ADDR_W-1:0] lowMask;
  logic [ADDR_W-1:0] cpuBase;
  logic [ADDR_W-1:0] pciBase;
  logic [WORD_W-1:0] desc0;
  logic [WORD_W-1:0] desc1;

  always_comb begin
    enabled = 1'b0;
    for (int i = 0; i < NUM_WORDS; i++) begin
      enabled = enabled | (|regWord[i]);
    end
  end

  assign desc0   = regWord[W_DESC0];
  assign desc1   = regWord[W_DESC1];
  assign isMsg   = (desc0[3:0] == TYPE_MSG);
  assign rawSize = regWord[W_CPU_LO][SIZE_W-1:0];

  always_comb begin
    if (isMsg) begin
      sizeBits = MSG_SIZE;
    end else if (rawSize < MIN_SIZE) begin
      sizeBits = MIN_SIZE;
    end else begin
      sizeBits = rawSize;
    end
  end

  assign lowMask = (ADDR_W'(1) << sizeBits) - ADDR_W'(1);
  assign cpuBase = {regWord[W_CPU_HI], regWord[W_CPU_LO][WORD_W-1:8], 8'h00};
  assign pciBase = isMsg ? '0 : {regWord[W_PCI_HI], regWord[W_PCI_LO][WORD_W-1:8], 8'h00};

  assign hit      = enabled && ((reqAddr & ~lowMask) == (cpuBase & ~lowMask));
  assign xlatAddr = (pciBase & ~lowMask) | (reqAddr & lowMask);

  always_comb begin
    desc.txnType = desc0[3:0];
    desc.hardId  = desc0[23];
    desc.func    = desc0[26:24];
    desc.dev     = desc0[31:27];
    desc.bus     = desc1[7:0];
  end

endmodule

// File: rtl/otr_datapath.sv
module otr_datapath
  import otr_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  parameter int IDX_W       = $clog2(NUM_REGIONS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  ctrlStrobe_t            strobe,
  input  logic [NUM_REGIONS-1:0] regionHot,
  input  logic [ADDR_W-1:0]      reqAddr,
  input  logic [7:0]             capBus,
  input  logic [4:0]             capDev,
  output logic                   rspValid,
  output logic                   rspMiss,
  output logic [IDX_W-1:0]       rspRegion,
  output logic [ADDR_W-1:0]      rspAddr,
  output descFields_t            rspDesc
);

  logic [NUM_REGIONS-1:0] hitVec;
  logic [ADDR_W-1:0]      xlat [NUM_REGIONS];
  descFields_t            descArr [NUM_REGIONS];

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_reg
    otr_region u_region (
      .clk      (clk),
      .rst      (rst),
      .we       (strobe.wrHit && regionHot[r]),
      .wordHot  (strobe.wordHot),
      .wrData   (strobe.wrData),
      .reqAddr  (reqAddr),
      .hit      (hitVec[r]),
      .xlatAddr (xlat[r]),
      .desc     (descArr[r])
    );
  end

  logic             found;
  logic [IDX_W-1:0] selIdx;

  // lowest index wins: scan downward so the last assignment is the lowest hit
  always_comb begin
    found  = 1'b0;
    selIdx = '0;
    for (int r = NUM_REGIONS - 1; r >= 0; r--) begin
      if (hitVec[r]) begin
        found  = 1'b1;
        selIdx = IDX_W'(r);
      end
    end
  end

  descFields_t selDesc;
  descFields_t nextDesc;

  assign selDesc = descArr[selIdx];

  always_comb begin
    nextDesc = '0;
    if (found) begin
      nextDesc.txnType = selDesc.txnType;
      nextDesc.hardId  = selDesc.hardId;
      nextDesc.func    = selDesc.func;
      nextDesc.dev     = selDesc.hardId ? selDesc.dev : capDev;
      nextDesc.bus     = selDesc.hardId ? selDesc.bus : capBus;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rspValid  <= 1'b0;
      rspMiss   <= 1'b0;
      rspRegion <= '0;
      rspAddr   <= '0;
      rspDesc   <= '0;
    end else begin
      rspValid <= strobe.lookup;
      if (strobe.lookup) begin
        rspMiss   <= !found;
        rspRegion <= found ? selIdx : '0;
        rspAddr   <= found ? xlat[selIdx] : reqAddr;
        rspDesc   <= nextDesc;
      end
    end
  end

endmodule

// File: rtl/otr_table.sv
module otr_table
  import otr_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  localparam int REGION_W   = $clog2(NUM_REGIONS) + 1,
  localparam int IDX_W      = $clog2(NUM_REGIONS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wrEn,
  input  logic [REGION_W-1:0]   wrRegion,
  input  logic [2:0]            wrWord,
  input  logic [31:0]           wrData,
  input  logic                  reqValid,
  input  logic [63:0]           reqAddr,
  input  logic [7:0]            capBus,
  input  logic [4:0]            capDev,
  output logic                  rspValid,
  output logic                  rspMiss,
  output logic [IDX_W-1:0]      rspRegion,
  output logic [63:0]           rspAddr,
  output logic [3:0]            rspType,
  output logic                  rspHardId,
  output logic [2:0]            rspFunc,
  output logic [4:0]            rspDev,
  output logic [7:0]            rspBus
);

  ctrlStrobe_t            strobe;
  logic [NUM_REGIONS-1:0] regionHot;
  descFields_t            rspDesc;

  otr_ctrl #(
    .NUM_REGIONS (NUM_REGIONS),
    .REGION_W    (REGION_W)
  ) u_ctrl (
    .wrEn      (wrEn),
    .wrRegion  (wrRegion),
    .wrWord    (wrWord),
    .wrData    (wrData),
    .reqValid  (reqValid),
    .strobe    (strobe),
    .regionHot (regionHot)
  );

  otr_datapath #(
    .NUM_REGIONS (NUM_REGIONS),
    .IDX_W       (IDX_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .regionHot (regionHot),
    .reqAddr   (reqAddr),
    .capBus    (capBus),
    .capDev    (capDev),
    .rspValid  (rspValid),
    .rspMiss   (rspMiss),
    .rspRegion (rspRegion),
    .rspAddr   (rspAddr),
    .rspDesc   (rspDesc)
  );

  assign rspType   = rspDesc.txnType;
  assign rspHardId = rspDesc.hardId;
  assign rspFunc   = rspDesc.func;
  assign rspDev    = rspDesc.dev;
  assign rspBus    = rspDesc.bus;

endmodule

// File: rtl/otr_table_chk.sv
module otr_table_chk #(
  parameter int NUM_REGIONS = 4,
  localparam int IDX_W      = $clog2(NUM_REGIONS)
) (
  input logic             clk,
  input logic             rst,
  input logic             reqValid,
  input logic [63:0]      reqAddr,
  input logic [7:0]       capBus,
  input logic [4:0]       capDev,
  input logic             rspValid,
  input logic             rspMiss,
  input logic [IDX_W-1:0] rspRegion,
  input logic [63:0]      rspAddr,
  input logic [3:0]       rspType,
  input logic             rspHardId,
  input logic [2:0]       rspFunc,
  input logic [4:0]       rspDev,
  input logic [7:0]       rspBus
);

  // R1: reset clears the result outputs
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!rspValid && !rspMiss && !rspHardId && rspAddr == 64'd0));

  // R11: one cycle from request to result
  a_r11_valid_follows: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> rspValid);

  a_r11_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> !rspValid);

  // R11: results hold without a request
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> ($stable(rspAddr) && $stable(rspMiss) && $stable(rspBus)));

  // R7: a miss passes the address through
  a_r7_miss_passthru: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> (!rspMiss || rspAddr == $past(reqAddr)));

  // R7: a miss carries no descriptor
  a_r7_miss_clean: assert property (@(posedge clk) disable iff (rst)
    rspMiss |-> (rspRegion == '0 && rspType == 4'd0 && !rspHardId &&
                 rspFunc == 3'd0 && rspDev == 5'd0 && rspBus == 8'd0));

  // R4: the minimum window keeps the low byte of the address
  a_r4_low_byte: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> (rspAddr[7:0] == $past(reqAddr[7:0])));

  // R10: without the forced ID the captured numbers are used
  a_r10_captured_id: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> (rspMiss || rspHardId ||
                  (rspBus == $past(capBus) && rspDev == $past(capDev))));

endmodule

bind otr_table otr_table_chk #(.NUM_REGIONS(NUM_REGIONS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reqValid  (reqValid),
  .reqAddr   (reqAddr),
  .capBus    (capBus),
  .capDev    (capDev),
  .rspValid  (rspValid),
  .rspMiss   (rspMiss),
  .rspRegion (rspRegion),
  .rspAddr   (rspAddr),
  .rspType   (rspType),
  .rspHardId (rspHardId),
  .rspFunc   (rspFunc),
  .rspDev    (rspDev),
  .rspBus    (rspBus)
);

// File: tb/tb_otr_table.sv
`timescale 1ns/1ps
module tb_otr_table;

  localparam int N        = 4;
  localparam int REGION_W = $clog2(N) + 1;
  localparam int IDX_W    = $clog2(N);

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                wrEn = 1'b0;
  logic [REGION_W-1:0] wrRegion = '0;
  logic [2:0]          wrWord = '0;
  logic [31:0]         wrData = '0;
  logic                reqValid = 1'b0;
  logic [63:0]         reqAddr = '0;
  logic [7:0]          capBus = '0;
  logic [4:0]          capDev = '0;
  logic                rspValid;
  logic                rspMiss;
  logic [IDX_W-1:0]    rspRegion;
  logic [63:0]         rspAddr;
  logic [3:0]          rspType;
  logic                rspHardId;
  logic [2:0]          rspFunc;
  logic [4:0]          rspDev;
  logic [7:0]          rspBus;

  always #2.5 clk = ~clk;

  otr_table #(.NUM_REGIONS(N)) dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrRegion(wrRegion), .wrWord(wrWord),
    .wrData(wrData), .reqValid(reqValid), .reqAddr(reqAddr), .capBus(capBus),
    .capDev(capDev), .rspValid(rspValid), .rspMiss(rspMiss), .rspRegion(rspRegion),
    .rspAddr(rspAddr), .rspType(rspType), .rspHardId(rspHardId), .rspFunc(rspFunc),
    .rspDev(rspDev), .rspBus(rspBus)
  );

  typedef struct packed {
    logic [63:0]      addr;
    logic             miss;
    logic [IDX_W-1:0] region;
    logic [3:0]       txnType;
    logic             hardId;
    logic [2:0]       func;
    logic [4:0]       dev;
    logic [7:0]       bus;
  } exp_t;

  exp_t  expQ[$];
  string tagQ[$];
  int    checks = 0;
  int    errors = 0;
  logic [31:0] shadow [N][6];

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model written from the requirements
  function automatic exp_t model(input logic [63:0] a, input logic [7:0] cb, input logic [4:0] cd);
    exp_t e;
    bit found = 0;
    e = '0;
    e.addr = a;
    e.miss = 1'b1;
    for (int r = 0; r < N; r++) begin
      bit en = 0;
      int nb;
      logic [63:0] m, cpuB, pciB;
      bit msg;
      for (int w = 0; w < 6; w++) en = en | (shadow[r][w] != 0);
      msg = (shadow[r][4][3:0] == 4'hA);
      nb  = msg ? 17 : ((shadow[r][0][5:0] < 8) ? 8 : int'(shadow[r][0][5:0]));
      m   = ~((64'd1 << nb) - 64'd1);
      cpuB = {shadow[r][1], shadow[r][0][31:8], 8'h00};
      pciB = msg ? 64'd0 : {shadow[r][3], shadow[r][2][31:8], 8'h00};
      if (!found && en && ((a & m) == (cpuB & m))) begin
        found    = 1;
        e.miss   = 1'b0;
        e.region = IDX_W'(r);
        e.addr   = (pciB & m) | (a & ~m);
        e.txnType = shadow[r][4][3:0];
        e.hardId = shadow[r][4][23];
        e.func   = shadow[r][4][26:24];
        e.dev    = shadow[r][4][23] ? shadow[r][4][31:27] : cd;
        e.bus    = shadow[r][4][23] ? shadow[r][5][7:0] : cb;
      end
    end
    return e;
  endfunction

  task automatic idle();
    @(negedge clk);
    wrEn = 0; reqValid = 0;
  endtask

  task automatic writeWord(input int r, input int w, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1; wrRegion = REGION_W'(r); wrWord = 3'(w); wrData = d; reqValid = 0;
    if (r < N && w < 6) shadow[r][w] = d;
  endtask

  task automatic lookup(input logic [63:0] a, input logic [7:0] cb, input logic [4:0] cd, input string tag);
    @(negedge clk);
    wrEn = 0; reqValid = 1; reqAddr = a; capBus = cb; capDev = cd;
    expQ.push_back(model(a, cb, cd));
    tagQ.push_back(tag);
  endtask

  // write and lookup in one cycle: the lookup sees the old contents (R2)
  task automatic writeAndLookup(input int r, input int w, input logic [31:0] d,
                                input logic [63:0] a, input string tag);
    @(negedge clk);
    wrEn = 1; wrRegion = REGION_W'(r); wrWord = 3'(w); wrData = d;
    reqValid = 1; reqAddr = a;
    expQ.push_back(model(a, capBus, capDev));
    tagQ.push_back(tag);
    shadow[r][w] = d;
  endtask

  task automatic writeRegion(input int r, input logic [31:0] cLo, input logic [31:0] cHi,
                             input logic [31:0] pLo, input logic [31:0] pHi,
                             input logic [31:0] d0, input logic [31:0] d1);
    writeWord(r, 0, cLo); writeWord(r, 1, cHi);
    writeWord(r, 2, pLo); writeWord(r, 3, pHi);
    writeWord(r, 4, d0);  writeWord(r, 5, d1);
  endtask

  // monitor: compare each result with the front of the queue
  always @(negedge clk) begin
    if (!rst && rspValid) begin
      if (expQ.size() == 0) begin
        check(0, "R11 unexpected result", {63'd0, rspValid}, 64'd0);
      end else begin
        exp_t e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(rspAddr == e.addr, {t, " addr"}, rspAddr, e.addr);
        check(rspMiss == e.miss, {t, " miss"}, 64'(rspMiss), 64'(e.miss));
        check(rspRegion == e.region, {t, " region"}, 64'(rspRegion), 64'(e.region));
        check({rspType, rspHardId, rspFunc, rspDev, rspBus} ==
              {e.txnType, e.hardId, e.func, e.dev, e.bus}, {t, " desc"},
              64'({rspType, rspHardId, rspFunc, rspDev, rspBus}),
              64'({e.txnType, e.hardId, e.func, e.dev, e.bus}));
      end
    end
  end

  int  cycles = 0;
  bit  done = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    for (int r = 0; r < N; r++) for (int w = 0; w < 6; w++) shadow[r][w] = '0;
    repeat (3) @(negedge clk);
    // R1: outputs cleared during reset
    check(!rspValid && !rspMiss && !rspHardId && rspAddr == 0, "R1 reset outputs",
          rspAddr, 64'd0);
    rst = 0;
    // R1 and R3: empty table misses
    lookup(64'h0000_0001_0000_1234, 8'h11, 5'h03, "R1 R3 R7 empty table");

    // R4 R5 R10 R8: memory region, 16-bit window, captured requester ID
    writeRegion(0, 32'h0000_0010, 32'h1, 32'h8000_0010, 32'h0, 32'h0300_0002, 32'h55);
    lookup(64'h0000_0001_0000_1234, 8'h11, 5'h03, "R4 R5 R8 R10 mem captured");
    lookup(64'h0000_0001_0000_FFFF, 8'hA5, 5'h1E, "R5 R10 new captured values");

    // R4 R8 R10: I/O region with size 4 treated as 8, forced requester ID
    writeRegion(1, 32'h2000_0004, 32'h0, 32'h0000_3000, 32'h0,
                32'h0600_0006 | 32'h0080_0000 | (32'd9 << 27) | (32'd5 << 24), 32'h42);
    lookup(64'h0000_0000_2000_00AB, 8'h22, 5'h04, "R4 R8 R10 io forced id");
    lookup(64'h0000_0000_2000_01AB, 8'h22, 5'h04, "R4 R7 io outside minimum window");

    // R6: overlapping wider region, lower index wins
    writeRegion(2, 32'h0000_0014, 32'h1, 32'h0, 32'h10, 32'h0000_0002, 32'h0);
    lookup(64'h0000_0001_0000_1234, 8'h33, 5'h05, "R6 overlap lowest wins");
    lookup(64'h0000_0001_0008_0000, 8'h33, 5'h05, "R6 R5 only wider region");

    // R9: message region, size forced 17 and PCI base zero
    writeRegion(3, 32'h4000_0000, 32'h0, 32'h1234_5600, 32'h7, 32'h0000_000A, 32'h0);
    lookup(64'h0000_0000_4001_FFFC, 8'h44, 5'h06, "R9 R8 message window");
    lookup(64'h0000_0000_4002_0000, 8'h44, 5'h06, "R9 R7 past message window");

    // R3: zeroing all six words disables region 0
    writeRegion(0, 0, 0, 0, 0, 0, 0);
    lookup(64'h0000_0001_0000_1234, 8'h55, 5'h07, "R3 disabled region skipped");

    // R2: same-cycle write uses old contents, next cycle new
    writeAndLookup(3, 4, 32'h0000_0002, 64'h0000_0000_4001_FFFC, "R2 old contents same cycle");
    lookup(64'h0000_0000_4001_FFFC, 8'h55, 5'h07, "R2 new contents next cycle");

    // R3: out-of-range region and word codes are ignored
    writeWord(N, 0, 32'h5000_0010);
    writeWord(1, 6, 32'hFFFF_FFFF);
    writeWord(1, 7, 32'hFFFF_FFFF);
    lookup(64'h0000_0000_5000_0000, 8'h66, 5'h08, "R3 ignored region index");
    lookup(64'h0000_0000_2000_00CD, 8'h66, 5'h08, "R3 ignored word codes");

    // R11: outputs hold without a request
    idle();
    held = rspAddr;
    idle();
    check(!rspValid, "R11 no valid when idle", {63'd0, rspValid}, 64'd0);
    check(rspAddr == held, "R11 address holds", rspAddr, held);
    repeat (3) idle();
    check(expQ.size() == 0, "R11 all results returned", 64'(expQ.size()), 64'd0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule